// File: doc/BRIEF.md
# Watchdog and Stop-Recovery Controller

This block sits beside a microcontroller core and runs two timers on the oscillator clock. The first is a watchdog. It counts cycles since the last service strobe and raises a one-cycle reset request when the selected limit is reached. The limit is either 8,176 or 262,128 cycles, and the watchdog can also be switched off. The second timer paces the exit from stop mode. After a wake-up event, the clock-ready flag stays low for either 32 or 4,096 cycles before it rises again.

The block also gates stop requests. When stop is permitted, a request puts the block into stop mode. When stop is not permitted, the request produces a one-cycle illegal-opcode reset request instead.

All of these options come from a four-bit configuration register. Software can write it once after reset. The block also raises a warning flag when the short recovery option is selected while the clock comes from an external crystal, because that pairing is unsafe.

Top module: `wdt_stop_ctrl`

## Requirements
- R1: While reset is held and right after it is released, `wd_rst`, `illop_rst`, `stop_active` and `cfg_warn` are 0, and `clk_ready` is 1. All configuration bits reset to 0.
- R2: The configuration bits take the value of `cfg_wdata` on the first cycle in which `cfg_we` is high after reset, and they hold that value until the next reset. Any later write is ignored. The bit fields are: bit 0 selects short recovery, bit 1 selects the short watchdog, bit 2 permits stop, and bit 3 disables the watchdog.
- R3: With bit 1 = 1 and bit 3 = 0, `wd_rst` is high exactly 8,176 cycles after the clock edge that sampled the last service strobe, provided no stop occurs in between. The count then restarts from zero.
- R4: With bit 1 = 0 and bit 3 = 0, the watchdog limit is 262,128 cycles, so no `wd_rst` appears at the 8,176-cycle mark.
- R5: With bit 3 = 1, `wd_rst` never rises.
- R6: A `wd_kick` strobe clears the watchdog count. `wd_rst` is low in the following cycle, and the next timeout is measured from that strobe.
- R7: With bit 2 = 1, a `stop_req` while running makes `stop_active` high and `clk_ready` low in the next cycle.
- R8: With bit 2 = 0, a `stop_req` while running gives a one-cycle `illop_rst` in the next cycle, and `stop_active` stays low.
- R9: A `wake` while in stop starts the recovery count. `clk_ready` and `stop_active` return to 1 and 0 exactly 32 cycles later when bit 0 = 1, or exactly 4,096 cycles later when bit 0 = 0.
- R10: While `stop_active` is high, the watchdog count neither advances nor times out. It resumes from its held value once running again.
- R11: A `stop_req` that arrives while in stop or while the recovery count runs has no effect. It causes no illegal-opcode pulse and no new stop.
- R12: `cfg_warn` equals configuration bit 0 ANDed with `ext_xtal`.
- R13: Each `wd_rst` timeout pulse and each `illop_rst` pulse from a single-cycle request lasts exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 4 | Configuration write data |
| ext_xtal | input | 1 | High when the clock comes from an external crystal |
| wd_kick | input | 1 | Watchdog service strobe |
| stop_req | input | 1 | Stop request strobe from the core |
| wake | input | 1 | Wake-up event |
| wd_rst | output | 1 | One-cycle watchdog reset request |
| illop_rst | output | 1 | One-cycle illegal-opcode reset request |
| stop_active | output | 1 | High in stop mode and during recovery |
| clk_ready | output | 1 | High when the clock is usable by the core |
| cfg_warn | output | 1 | Short recovery selected with an external crystal |

## Verification
The watchdog is tried in five patterns, and each one separates a distinct fault.
- **Long limit with no service.** The bench runs past the short mark and expects no reset. This catches a swapped limit select.
- **Short limit from a service strobe.** This pins the exact timeout cycle, so an off-by-one count is caught.
- **Service just before expiry.** This shows the strobe moves the deadline rather than only masking the pulse.
- **Stop taken partway through a count.** The timeout is expected at the cycle that only a held count produces. A counter that kept running would fire about 16,000 cycles early, and one that was cleared would fire about 800 cycles late.
- **Watchdog disabled while the short limit is selected.** This separates the disable bit from the limit select.

Stop handling is tried in three configurations: permitted with short recovery, forbidden, and permitted with long recovery. In addition, a second configuration write and a stop request during recovery each have to leave no visible trace.

// File: rtl/wsc_pkg.sv
package wsc_pkg;

   localparam int unsigned CFG_W = 4;

   // Field order defines the bit positions seen by software (bit 3 down to bit 0).
   typedef struct packed {
      logic wd_off;     // bit 3: watchdog disabled
      logic stop_en;    // bit 2: stop request permitted
      logic wd_short;   // bit 1: short watchdog limit
      logic rec_short;  // bit 0: short stop-recovery delay
   } wsc_cfg_t;

   typedef enum logic [1:0] {
      ST_RUN     = 2'd0,
      ST_STOP    = 2'd1,
      ST_RECOVER = 2'd2
   } wsc_state_t;

endpackage

// File: rtl/wsc_cfg_latch.sv
module wsc_cfg_latch #(
   parameter int unsigned W = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         we,
   input  logic [W-1:0] wdata,
   output logic [W-1:0] bits
);

   if (W < 1) begin : g_bad_w
      $error("wsc_cfg_latch: W must be at least 1");
   end

   logic locked;

   always_ff @(posedge clk) begin
      if (!rst_n)
         locked <= 1'b0;
      else if (we)
         locked <= 1'b1;
   end

   for (genvar i = 0; i < W; i++) begin : g_bit
      logic q;
      always_ff @(posedge clk) begin
         if (!rst_n)
            q <= 1'b0;
         else if (we && !locked)
            q <= wdata[i];
      end
      assign bits[i] = q;
   end

endmodule

// File: rtl/wsc_watchdog.sv
module wsc_watchdog #(
   parameter int unsigned SHORT_CYC = 8176,
   parameter int unsigned LONG_CYC  = 262128
) (
   input  logic clk,
   input  logic rst_n,
   input  logic use_short,
   input  logic disable_i,
   input  logic hold,
   input  logic kick,
   output logic bark
);

   localparam int unsigned MAX_CYC = (SHORT_CYC > LONG_CYC) ? SHORT_CYC : LONG_CYC;
   localparam int unsigned CW      = (MAX_CYC > 2) ? $clog2(MAX_CYC) : 1;

   if (SHORT_CYC < 2 || LONG_CYC < 2) begin : g_bad_lim
      $error("wsc_watchdog: both limits must be at least 2 cycles");
   end

   logic [CW-1:0] cnt;
   logic [CW-1:0] last;

   if (SHORT_CYC == LONG_CYC) begin : g_one_limit
      logic unused_sel;
      assign unused_sel = use_short;
      assign last = CW'(LONG_CYC - 1);
   end else begin : g_two_limits
      assign last = use_short ? CW'(SHORT_CYC - 1) : CW'(LONG_CYC - 1);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt  <= '0;
         bark <= 1'b0;
      end else begin
         bark <= 1'b0;
         if (disable_i || kick) begin
            cnt <= '0;
         end else if (!hold) begin
            // ">=" keeps a count left above a freshly shortened limit from wrapping.
            if (cnt >= last) begin
               cnt  <= '0;
               bark <= 1'b1;
            end else begin
               cnt <= cnt + 1'b1;
            end
         end
      end
   end

endmodule

// File: rtl/wsc_stop_seq.sv
module wsc_stop_seq
   import wsc_pkg::*;
#(
   parameter int unsigned SHORT_CYC = 32,
   parameter int unsigned LONG_CYC  = 4096
) (
   input  logic clk,
   input  logic rst_n,
   input  logic stop_en,
   input  logic rec_short,
   input  logic stop_req,
   input  logic wake,
   output logic illop_pulse,
   output logic in_stop,
   output logic ready
);

   localparam int unsigned MAX_CYC = (SHORT_CYC > LONG_CYC) ? SHORT_CYC : LONG_CYC;
   localparam int unsigned CW      = (MAX_CYC > 2) ? $clog2(MAX_CYC) : 1;

   if (SHORT_CYC < 1 || LONG_CYC < 1) begin : g_bad_rec
      $error("wsc_stop_seq: recovery delays must be at least 1 cycle");
   end

   wsc_state_t    st;
   logic [CW-1:0] rcnt;
   logic [CW-1:0] last;

   if (SHORT_CYC == LONG_CYC) begin : g_one_delay
      logic unused_sel;
      assign unused_sel = rec_short;
      assign last = CW'(LONG_CYC - 1);
   end else begin : g_two_delays
      assign last = rec_short ? CW'(SHORT_CYC - 1) : CW'(LONG_CYC - 1);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st          <= ST_RUN;
         rcnt        <= '0;
         illop_pulse <= 1'b0;
      end else begin
         illop_pulse <= 1'b0;
         case (st)
            ST_RUN: begin
               if (stop_req) begin
                  if (stop_en)
                     st <= ST_STOP;
                  else
                     illop_pulse <= 1'b1;
               end
            end
            ST_STOP: begin
               if (wake) begin
                  st   <= ST_RECOVER;
                  rcnt <= '0;
               end
            end
            ST_RECOVER: begin
               if (rcnt == last)
                  st <= ST_RUN;
               else
                  rcnt <= rcnt + 1'b1;
            end
            default: st <= ST_RUN;
         endcase
      end
   end

   assign in_stop = (st != ST_RUN);
   assign ready   = (st == ST_RUN);

endmodule

// File: rtl/wdt_stop_ctrl.sv
module wdt_stop_ctrl
   import wsc_pkg::*;
#(
   parameter int unsigned WD_SHORT_CYC  = 8176,
   parameter int unsigned WD_LONG_CYC   = 262128,
   parameter int unsigned REC_SHORT_CYC = 32,
   parameter int unsigned REC_LONG_CYC  = 4096
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_we,
   input  logic [CFG_W-1:0] cfg_wdata,
   input  logic             ext_xtal,
   input  logic             wd_kick,
   input  logic             stop_req,
   input  logic             wake,
   output logic             wd_rst,
   output logic             illop_rst,
   output logic             stop_active,
   output logic             clk_ready,
   output logic             cfg_warn
);

   if ($bits(wsc_cfg_t) != CFG_W) begin : g_bad_cfg
      $error("wdt_stop_ctrl: configuration struct width mismatch");
   end

   logic [CFG_W-1:0] cfg_bits;
   wsc_cfg_t         cfg;

   assign cfg = wsc_cfg_t'(cfg_bits);

   wsc_cfg_latch #(
      .W (CFG_W)
   ) u_cfg (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (cfg_we),
      .wdata (cfg_wdata),
      .bits  (cfg_bits)
   );

   wsc_watchdog #(
      .SHORT_CYC (WD_SHORT_CYC),
      .LONG_CYC  (WD_LONG_CYC)
   ) u_wd (
      .clk       (clk),
      .rst_n     (rst_n),
      .use_short (cfg.wd_short),
      .disable_i (cfg.wd_off),
      .hold      (stop_active),
      .kick      (wd_kick),
      .bark      (wd_rst)
   );

   wsc_stop_seq #(
      .SHORT_CYC (REC_SHORT_CYC),
      .LONG_CYC  (REC_LONG_CYC)
   ) u_stop (
      .clk         (clk),
      .rst_n       (rst_n),
      .stop_en     (cfg.stop_en),
      .rec_short   (cfg.rec_short),
      .stop_req    (stop_req),
      .wake        (wake),
      .illop_pulse (illop_rst),
      .in_stop     (stop_active),
      .ready       (clk_ready)
   );

   assign cfg_warn = cfg.rec_short & ext_xtal;

endmodule

// File: rtl/wsc_checker.sv
module wsc_checker (
   input logic       clk,
   input logic       rst_n,
   input logic       cfg_we,
   input logic       stop_req,
   input logic       wd_kick,
   input logic       wd_rst,
   input logic       illop_rst,
   input logic       stop_active,
   input logic       clk_ready,
   input logic [3:0] cfg_bits
);

   logic written;

   always_ff @(posedge clk) begin
      if (!rst_n)
         written <= 1'b0;
      else if (cfg_we)
         written <= 1'b1;
   end

   a_r2_write_once: assert property (@(posedge clk) disable iff (!rst_n)
      written |=> $stable(cfg_bits));

   a_r5_disabled_silent: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_bits[3] && $past(cfg_bits[3])) |-> !wd_rst);

   a_r6_kick_clears: assert property (@(posedge clk) disable iff (!rst_n)
      wd_kick |=> !wd_rst);

   a_r7_stop_entry: assert property (@(posedge clk) disable iff (!rst_n)
      (!stop_active && stop_req && cfg_bits[2]) |=> (stop_active && !clk_ready));

   a_r8_illegal_stop: assert property (@(posedge clk) disable iff (!rst_n)
      (!stop_active && stop_req && !cfg_bits[2]) |=> (illop_rst && !stop_active));

   a_r10_hold_in_stop: assert property (@(posedge clk) disable iff (!rst_n)
      (stop_active && $past(stop_active)) |-> !wd_rst);

   a_r11_busy_ignore: assert property (@(posedge clk) disable iff (!rst_n)
      (stop_active && stop_req) |=> !illop_rst);

   a_r13_wd_single: assert property (@(posedge clk) disable iff (!rst_n)
      wd_rst |=> !wd_rst);

endmodule

bind wdt_stop_ctrl wsc_checker u_wsc_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .cfg_we      (cfg_we),
   .stop_req    (stop_req),
   .wd_kick     (wd_kick),
   .wd_rst      (wd_rst),
   .illop_rst   (illop_rst),
   .stop_active (stop_active),
   .clk_ready   (clk_ready),
   .cfg_bits    (cfg_bits)
);

// File: tb/tb_wdt_stop_ctrl.sv
module tb_wdt_stop_ctrl;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cfg_we = 1'b0;
   logic [3:0] cfg_wdata = 4'h0;
   logic       ext_xtal = 1'b1;
   logic       wd_kick = 1'b0;
   logic       stop_req = 1'b0;
   logic       wake = 1'b0;
   logic       wd_rst, illop_rst, stop_active, clk_ready, cfg_warn;

   always #4 clk = ~clk;  // 125 MHz

   wdt_stop_ctrl dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .cfg_we      (cfg_we),
      .cfg_wdata   (cfg_wdata),
      .ext_xtal    (ext_xtal),
      .wd_kick     (wd_kick),
      .stop_req    (stop_req),
      .wake        (wake),
      .wd_rst      (wd_rst),
      .illop_rst   (illop_rst),
      .stop_active (stop_active),
      .clk_ready   (clk_ready),
      .cfg_warn    (cfg_warn)
   );

   int cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   typedef enum int {S_WD, S_ILL, S_STOP, S_RDY, S_WARN, S_WDCNT, S_ILLCNT} sig_e;
   typedef struct {
      int    at;
      sig_e  sig;
      int    val;
      string req;
   } exp_t;

   exp_t sb[$];
   int   n_cmp = 0;
   int   n_bad = 0;
   int   wd_seen = 0;
   int   ill_seen = 0;
   bit   done = 1'b0;

   task automatic expect_at(input int at, input sig_e s, input int v, input string r);
      exp_t e;
      e.at = at; e.sig = s; e.val = v; e.req = r;
      sb.push_back(e);
   endtask

   function automatic int observe(input sig_e s);
      case (s)
         S_WD:     return int'(wd_rst);
         S_ILL:    return int'(illop_rst);
         S_STOP:   return int'(stop_active);
         S_RDY:    return int'(clk_ready);
         S_WARN:   return int'(cfg_warn);
         S_WDCNT:  return wd_seen;
         default:  return ill_seen;
      endcase
   endfunction

   // Monitor: counts pulses, then pops and compares every item due this cycle.
   always @(negedge clk) begin
      if (wd_rst)    wd_seen++;
      if (illop_rst) ill_seen++;
      for (int i = sb.size() - 1; i >= 0; i--) begin
         if (sb[i].at == cyc) begin
            int act;
            act = observe(sb[i].sig);
            n_cmp++;
            if (act != sb[i].val) begin
               n_bad++;
               $display("FAIL %s: cycle %0d %s actual %0d expected %0d",
                        sb[i].req, cyc, sb[i].sig.name(), act, sb[i].val);
            end
            sb.delete(i);
         end
      end
   end

   task automatic go(input int c);
      while (cyc < c) @(negedge clk);
   endtask

   task automatic finish_run();
      if (sb.size() != 0) begin
         n_bad++;
         $display("FAIL scoreboard: %0d items never compared, expected 0", sb.size());
      end
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: run hung at cycle %0d, expected end by 72300", cyc);
         finish_run();
      end
   end

   initial begin
      // ---------- expectations, phase 1 ----------
      expect_at(5, S_RDY, 1, "R1");
      expect_at(5, S_STOP, 0, "R1");
      expect_at(5, S_WD, 0, "R1");
      expect_at(5, S_ILL, 0, "R1");
      expect_at(5, S_WARN, 0, "R1");
      expect_at(9000, S_WDCNT, 0, "R4");
      expect_at(9001, S_WARN, 1, "R12");
      expect_at(9003, S_WARN, 1, "R2");
      expect_at(17176, S_WD, 0, "R3");
      expect_at(17177, S_WD, 1, "R3");
      expect_at(17178, S_WD, 0, "R13");
      expect_at(17178, S_WDCNT, 1, "R2");
      expect_at(25400, S_WDCNT, 1, "R6");
      expect_at(26001, S_WARN, 0, "R12");
      expect_at(33176, S_WD, 0, "R6");
      expect_at(33177, S_WD, 1, "R6");
      expect_at(34000, S_STOP, 0, "R7");
      expect_at(34001, S_STOP, 1, "R7");
      expect_at(34001, S_RDY, 0, "R7");
      expect_at(34001, S_ILL, 0, "R7");
      expect_at(49999, S_WDCNT, 2, "R10");
      expect_at(50012, S_ILLCNT, 0, "R11");
      expect_at(50032, S_RDY, 0, "R9");
      expect_at(50033, S_RDY, 1, "R9");
      expect_at(50033, S_STOP, 0, "R9");
      expect_at(50040, S_STOP, 0, "R11");
      expect_at(57384, S_WD, 0, "R10");
      expect_at(57385, S_WD, 1, "R10");
      // ---------- phase 2 ----------
      expect_at(58002, S_WD, 0, "R1");
      expect_at(58002, S_RDY, 1, "R1");
      expect_at(58101, S_ILL, 1, "R8");
      expect_at(58101, S_STOP, 0, "R8");
      expect_at(58101, S_RDY, 1, "R8");
      expect_at(58102, S_ILL, 0, "R13");
      expect_at(58102, S_ILLCNT, 1, "R8");
      expect_at(67010, S_WDCNT, 3, "R5");
      // ---------- phase 3 ----------
      expect_at(68012, S_WARN, 0, "R12");
      expect_at(68021, S_STOP, 1, "R7");
      expect_at(68021, S_RDY, 0, "R7");
      expect_at(72196, S_RDY, 0, "R9");
      expect_at(72197, S_RDY, 1, "R9");
      expect_at(72197, S_STOP, 0, "R9");

      // ---------- driver, phase 1: short recovery, short watchdog, stop permitted ----------
      go(4);     rst_n = 1'b1;
      go(9000);  cfg_we = 1'b1; cfg_wdata = 4'b0111; wd_kick = 1'b1;
      go(9001);  cfg_wdata = 4'b1000; wd_kick = 1'b0;   // second write must be ignored (R2)
      go(9002);  cfg_we = 1'b0; cfg_wdata = 4'h0;
      go(25000); wd_kick = 1'b1;
      go(25001); wd_kick = 1'b0;
      go(26000); ext_xtal = 1'b0;
      go(34000); stop_req = 1'b1;
      go(34001); stop_req = 1'b0;
      go(40000); stop_req = 1'b1;                        // in stop: ignored (R11)
      go(40001); stop_req = 1'b0;
      go(50000); wake = 1'b1;
      go(50001); wake = 1'b0;
      go(50010); stop_req = 1'b1;                        // during recovery: ignored (R11)
      go(50011); stop_req = 1'b0;

      // ---------- phase 2: watchdog off with short limit, stop forbidden ----------
      go(58000); rst_n = 1'b0;
      go(58004); rst_n = 1'b1;
      go(58010); cfg_we = 1'b1; cfg_wdata = 4'b1010;
      go(58011); cfg_we = 1'b0; cfg_wdata = 4'h0;
      go(58020); cfg_we = 1'b1; cfg_wdata = 4'b0100;     // ignored (R2)
      go(58021); cfg_we = 1'b0; cfg_wdata = 4'h0;
      go(58100); stop_req = 1'b1;
      go(58101); stop_req = 1'b0;

      // ---------- phase 3: long recovery, stop permitted, crystal present ----------
      go(67990); ext_xtal = 1'b1;
      go(68000); rst_n = 1'b0;
      go(68004); rst_n = 1'b1;
      go(68010); cfg_we = 1'b1; cfg_wdata = 4'b0100;
      go(68011); cfg_we = 1'b0; cfg_wdata = 4'h0;
      go(68020); stop_req = 1'b1;
      go(68021); stop_req = 1'b0;
      go(68100); wake = 1'b1;
      go(68101); wake = 1'b0;

      go(72300);
      done = 1'b1;
      finish_run();
   end

endmodule